// File: doc/BRIEF.md
# Paired-Page Address Translation Buffer

This block maps 32-bit virtual addresses onto physical addresses through a small fully associative table. Every slot covers two neighbouring virtual pages, an even one and an odd one, and stores a separate physical frame, valid flag and dirty flag for each half. The page size is chosen per slot from five sizes between 1 KB and 256 KB. A lookup compares the address and the current address space ID against all slots in the same cycle. The registered response appears one clock later: a physical address and hit flag, or one of three exception flags (miss, invalid, modified).

Software loads a slot through the write port. It either names the slot directly or lets a free-running down-counter pick it. Two fixed kernel windows skip the table and are mapped by dropping the top three address bits. If one lookup matches more than one slot, the block enters a sticky shutdown state. In that state every mapped lookup misses, and only reset clears it.

Top module: `pair_tlb`

## Requirements
- R1: Reset clears the shutdown flag and all response outputs, and marks every slot unused. A mapped lookup after reset misses until a slot is written.
- R2: A lookup whose address has bits [31:30] equal to 2'b10 (0x80000000–0xBFFFFFFF) hits one cycle later with physical address {3'b000, va[28:0]}. This holds whatever the slot contents or the shutdown state.
- R3: A hit builds the physical address from the frame bits above the page offset and the virtual address bits below it. The frame field holds physical address bits [31:10]. Virtual bit k, where k is the offset width, picks the odd half when it is 1 and the even half when it is 0.
- R4: The size code sets the offset width k: code 0 gives 10 bits, 1 gives 12, 2 gives 14 and 3 gives 16; codes 4 to 7 give 18. Only virtual bits above k are compared against the slot's tag, which holds va[31:11].
- R5: A slot matches only when its ID equals the lookup ID, unless its global bit is set.
- R6: At most one of hit, miss, invalid and modified is set per response, and exactly one is set when the response is valid. Any response that is not a hit drives a physical address of 0.
- R7: A match on a half whose valid bit is 0 reports invalid instead of hit.
- R8: A store that matches a half whose dirty bit is 0 reports modified. A load to that half hits, and a store to a dirty half hits.
- R9: With the random select low, a write loads the slot given by the index input.
- R10: With the random select high, a write loads the slot named by the random counter. The counter is 31 after reset, decrements on every clock, and wraps from the floor (default 8) back to 31.
- R11: A mapped lookup that matches two or more slots reports a miss and sets the shutdown flag. The flag stays set until reset, and every mapped lookup made while it is set misses.
- R12: A lookup in the same cycle as a write sees the old contents. A lookup in the following cycle sees the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_va | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Current address space ID |
| lk_store | input | 1 | Lookup is for a store |
| wr_en | input | 1 | Load one slot |
| wr_rand | input | 1 | Use the random counter as the slot number |
| wr_idx | input | 5 | Slot number used when wr_rand is low |
| wr_vpn | input | 21 | Virtual tag, va[31:11] |
| wr_asid | input | 8 | Slot address space ID |
| wr_glob | input | 1 | Skip the ID compare |
| wr_psz | input | 3 | Page size code |
| wr_pfn0 | input | 22 | Even-half frame, PA[31:10] |
| wr_pfn1 | input | 22 | Odd-half frame, PA[31:10] |
| wr_v0 | input | 1 | Even half valid |
| wr_v1 | input | 1 | Odd half valid |
| wr_d0 | input | 1 | Even half dirty |
| wr_d1 | input | 1 | Odd half dirty |
| rsp_valid | output | 1 | Response for last cycle's lookup |
| rsp_hit | output | 1 | Translation produced |
| rsp_pa | output | 32 | Physical address, 0 unless hit |
| rsp_miss | output | 1 | No usable match, multiple match or shutdown |
| rsp_invalid | output | 1 | Matched half not valid |
| rsp_modified | output | 1 | Store to clean half |
| tlb_shutdown | output | 1 | Sticky multiple-match state |

## Verification
Lookups are tried against slots of every size code, so the position of the half-select bit and the width of the compared tag are both tested. Each slot gets addresses in its even half, its odd half and just outside its range, which separates a wrong mask from a wrong half select. The same addresses are sent with a wrong ID, with a global slot, and as loads and as stores. This separates the miss, invalid and modified cases from a hit. Further directed sequences check the random slot choice at its wrap and floor, a write racing a lookup, and a duplicate match followed by lookups into the kernel windows and the mapped space.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int TLB_VA_W   = 32;
  localparam int TLB_ASID_W = 8;
  localparam int TLB_VPN_W  = 21;  // va[31:11]
  localparam int TLB_PFN_W  = 22;  // pa[31:10]
  localparam int TLB_PSZ_W  = 3;

  typedef struct packed {
    logic [TLB_VPN_W-1:0]  vpn;
    logic [TLB_ASID_W-1:0] asid;
    logic                  glob;
    logic [TLB_PSZ_W-1:0]  psz;
    logic [TLB_PFN_W-1:0]  pfn0;
    logic [TLB_PFN_W-1:0]  pfn1;
    logic                  v0;
    logic                  v1;
    logic                  d0;
    logic                  d1;
  } tlb_ent_t;

  // offset width in bits for a size code
  function automatic logic [4:0] off_bits(input logic [TLB_PSZ_W-1:0] code);
    case (code)
      3'd0:    return 5'd10;
      3'd1:    return 5'd12;
      3'd2:    return 5'd14;
      3'd3:    return 5'd16;
      default: return 5'd18;
    endcase
  endfunction
endpackage

// File: rtl/tlb_way_match.sv
module tlb_way_match
  import tlb_pkg::*;
(
  input  logic                  used,
  input  tlb_ent_t              ent,
  input  logic [TLB_VA_W-1:0]   va,
  input  logic [TLB_ASID_W-1:0] asid,
  output logic                  hit,
  output logic                  odd,
  output logic [TLB_VA_W-1:0]   off_mask
);
  logic [4:0]           k;
  logic [TLB_VPN_W-1:0] cmp_mask;
  logic                 tag_eq;
  logic                 id_ok;

  always_comb begin
    k        = off_bits(ent.psz);
    off_mask = (32'h1 << k) - 32'h1;
    // compare only va bits above k, i.e. tag bits from index k-10 upward
    cmp_mask = {TLB_VPN_W{1'b1}} << (k - 5'd10);
    tag_eq   = ((ent.vpn ^ va[TLB_VA_W-1:11]) & cmp_mask) == '0;
    id_ok    = ent.glob | (ent.asid == asid);
    hit      = used & tag_eq & id_ok;
    odd      = va[k];
  end
endmodule

// File: rtl/tlb_rand_ctr.sv
module tlb_rand_ctr #(
  parameter int ENTRIES = 32,
  parameter int FLOOR   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(ENTRIES - 1);
  localparam logic [IDX_W-1:0] BOT = IDX_W'(FLOOR);

  always_ff @(posedge clk) begin
    if (rst)             idx <= TOP;
    else if (idx == BOT) idx <= TOP;
    else                 idx <= idx - 1'b1;
  end
endmodule

// File: rtl/pair_tlb.sv
module pair_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES    = 32,
  parameter int RAND_FLOOR = 8,
  localparam int IDX_W     = $clog2(ENTRIES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  lk_valid,
  input  logic [TLB_VA_W-1:0]   lk_va,
  input  logic [TLB_ASID_W-1:0] lk_asid,
  input  logic                  lk_store,
  input  logic                  wr_en,
  input  logic                  wr_rand,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [TLB_VPN_W-1:0]  wr_vpn,
  input  logic [TLB_ASID_W-1:0] wr_asid,
  input  logic                  wr_glob,
  input  logic [TLB_PSZ_W-1:0]  wr_psz,
  input  logic [TLB_PFN_W-1:0]  wr_pfn0,
  input  logic [TLB_PFN_W-1:0]  wr_pfn1,
  input  logic                  wr_v0,
  input  logic                  wr_v1,
  input  logic                  wr_d0,
  input  logic                  wr_d1,
  output logic                  rsp_valid,
  output logic                  rsp_hit,
  output logic [TLB_VA_W-1:0]   rsp_pa,
  output logic                  rsp_miss,
  output logic                  rsp_invalid,
  output logic                  rsp_modified,
  output logic                  tlb_shutdown
);
  tlb_ent_t             tbl [ENTRIES];
  logic [ENTRIES-1:0]   used;
  logic [IDX_W-1:0]     rnd_idx;
  logic [IDX_W-1:0]     wr_slot;

  logic [ENTRIES-1:0]   way_hit;
  logic [ENTRIES-1:0]   way_odd;
  logic [TLB_VA_W-1:0]  way_om [ENTRIES];

  logic [TLB_PFN_W-1:0] sel_pfn;
  logic [TLB_VA_W-1:0]  sel_om;
  logic                 sel_v, sel_d;
  logic                 any_hit, multi, bypass;
  logic [TLB_VA_W-1:0]  map_pa;

  tlb_rand_ctr #(.ENTRIES(ENTRIES), .FLOOR(RAND_FLOOR)) u_rand (
    .clk(clk), .rst(rst), .idx(rnd_idx)
  );

  assign wr_slot = wr_rand ? rnd_idx : wr_idx;

  // entry storage: no reset on the payload so it can map to RAM
  always_ff @(posedge clk) begin
    if (wr_en)
      tbl[wr_slot] <= '{vpn: wr_vpn, asid: wr_asid, glob: wr_glob, psz: wr_psz,
                        pfn0: wr_pfn0, pfn1: wr_pfn1,
                        v0: wr_v0, v1: wr_v1, d0: wr_d0, d1: wr_d1};
  end

  always_ff @(posedge clk) begin
    if (rst)        used <= '0;
    else if (wr_en) used[wr_slot] <= 1'b1;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_way
    tlb_way_match u_match (
      .used(used[g]), .ent(tbl[g]), .va(lk_va), .asid(lk_asid),
      .hit(way_hit[g]), .odd(way_odd[g]), .off_mask(way_om[g])
    );
  end

  always_comb begin
    sel_pfn = '0;
    sel_om  = '0;
    sel_v   = 1'b0;
    sel_d   = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (way_hit[i]) begin
        sel_pfn |= way_odd[i] ? tbl[i].pfn1 : tbl[i].pfn0;
        sel_v   |= way_odd[i] ? tbl[i].v1   : tbl[i].v0;
        sel_d   |= way_odd[i] ? tbl[i].d1   : tbl[i].d0;
        sel_om  |= way_om[i];
      end
    end
    any_hit = |way_hit;
    multi   = |(way_hit & (way_hit - ENTRIES'(1)));
    bypass  = lk_va[31:30] == 2'b10;
    map_pa  = ({sel_pfn, 10'b0} & ~sel_om) | (lk_va & sel_om);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_pa       <= '0;
      rsp_miss     <= 1'b0;
      rsp_invalid  <= 1'b0;
      rsp_modified <= 1'b0;
      tlb_shutdown <= 1'b0;
    end else begin
      rsp_valid    <= lk_valid;
      rsp_hit      <= 1'b0;
      rsp_pa       <= '0;
      rsp_miss     <= 1'b0;
      rsp_invalid  <= 1'b0;
      rsp_modified <= 1'b0;
      if (lk_valid) begin
        if (bypass) begin
          rsp_hit <= 1'b1;
          rsp_pa  <= {3'b000, lk_va[28:0]};
        end else if (tlb_shutdown || multi || !any_hit) begin
          rsp_miss <= 1'b1;
          if (multi) tlb_shutdown <= 1'b1;
        end else if (!sel_v) begin
          rsp_invalid <= 1'b1;
        end else if (lk_store && !sel_d) begin
          rsp_modified <= 1'b1;
        end else begin
          rsp_hit <= 1'b1;
          rsp_pa  <= map_pa;
        end
      end
    end
  end
endmodule

// File: rtl/pair_tlb_chk.sv
module pair_tlb_chk (
  input logic        clk,
  input logic        rst,
  input logic        lk_valid,
  input logic [31:0] lk_va,
  input logic        rsp_valid,
  input logic        rsp_hit,
  input logic [31:0] rsp_pa,
  input logic        rsp_miss,
  input logic        rsp_invalid,
  input logic        rsp_modified,
  input logic        tlb_shutdown
);
  // R1: first cycle out of reset shows a clear state
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!tlb_shutdown && !rsp_valid));

  // R2: kernel windows bypass the table
  a_r2_bypass: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_va[31:30] == 2'b10) |=>
      (rsp_hit && rsp_pa == {3'b000, $past(lk_va[28:0])}));

  // R6: exactly one outcome per valid response
  a_r6_one_outcome: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_invalid, rsp_modified}) == 1);

  // R6: no outcome and zero address without a request
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (!rsp_hit && !rsp_miss && !rsp_invalid && !rsp_modified && rsp_pa == '0));

  // R11: shutdown is sticky
  a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
    tlb_shutdown |=> tlb_shutdown);

  // R11: mapped lookups miss during shutdown
  a_r11_forced_miss: assert property (@(posedge clk) disable iff (rst)
    (tlb_shutdown && lk_valid && lk_va[31:30] != 2'b10) |=> rsp_miss);
endmodule

bind pair_tlb pair_tlb_chk u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_va(lk_va),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pa(rsp_pa),
  .rsp_miss(rsp_miss), .rsp_invalid(rsp_invalid),
  .rsp_modified(rsp_modified), .tlb_shutdown(tlb_shutdown)
);

// File: tb/tb_pair_tlb.sv
module tb_pair_tlb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0, lk_store = 1'b0;
  logic [31:0] lk_va = '0;
  logic [7:0]  lk_asid = '0;
  logic        wr_en = 1'b0, wr_rand = 1'b0, wr_glob = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [20:0] wr_vpn = '0;
  logic [7:0]  wr_asid = '0;
  logic [2:0]  wr_psz = '0;
  logic [21:0] wr_pfn0 = '0, wr_pfn1 = '0;
  logic        wr_v0 = 1'b0, wr_v1 = 1'b0, wr_d0 = 1'b0, wr_d1 = 1'b0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_invalid, rsp_modified, tlb_shutdown;
  logic [31:0] rsp_pa;

  int n_chk = 0, n_bad = 0;
  int ecnt = 0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) ecnt <= 0;
    else     ecnt <= ecnt + 1;
  end

  pair_tlb dut (.*);

  // {va, asid, store(4), flags {hit,miss,inv,mod}, pa}
  localparam int NV = 18;
  localparam logic [79:0] VECS [NV] = '{
    {32'h00400ABC, 8'd5, 4'd0, 4'b1000, 32'h00040ABC},  // R3 even 4K
    {32'h00401123, 8'd5, 4'd0, 4'b1000, 32'h00080123},  // R3 odd 4K, clean load
    {32'h00401123, 8'd5, 4'd1, 4'b0001, 32'h00000000},  // R8 store clean
    {32'h00400ABC, 8'd6, 4'd0, 4'b0100, 32'h00000000},  // R5 wrong id
    {32'h00400ABC, 8'd5, 4'd1, 4'b1000, 32'h00040ABC},  // R8 store dirty
    {32'h10034567, 8'd9, 4'd0, 4'b1000, 32'h04034567},  // R5 global, R4 256K
    {32'h10040000, 8'd9, 4'd0, 4'b0010, 32'h00000000},  // R7 invalid odd
    {32'h10080000, 8'd9, 4'd0, 4'b0100, 32'h00000000},  // R4 above range
    {32'h20000A55, 8'd2, 4'd0, 4'b1000, 32'h00001655},  // R4 1K even
    {32'h20000E01, 8'd2, 4'd0, 4'b1000, 32'h00001E01},  // R4 1K odd
    {32'h20001A55, 8'd2, 4'd0, 4'b0100, 32'h00000000},  // R6 miss
    {32'h81234567, 8'd0, 4'd0, 4'b1000, 32'h01234567},  // R2 low window
    {32'hBFFFFFF0, 8'd0, 4'd0, 4'b1000, 32'h1FFFFFF0},  // R2 high window
    {32'hC0000000, 8'd0, 4'd0, 4'b0100, 32'h00000000},  // R6 mapped, empty
    {32'h00000000, 8'd0, 4'd0, 4'b0100, 32'h00000000},  // R1 unused slots
    {32'h30012345, 8'd1, 4'd0, 4'b1000, 32'h00302345},  // R4 64K odd
    {32'h40003FFF, 8'd1, 4'd0, 4'b1000, 32'h00013FFF},  // R4 16K even
    {32'h40004001, 8'd1, 4'd0, 4'b1000, 32'h00020001}   // R4 16K odd
  };

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] resp();
    return {rsp_hit, rsp_miss, rsp_invalid, rsp_modified, rsp_pa};
  endfunction

  task automatic lookup(input logic [31:0] va, input logic [7:0] id, input logic st);
    @(negedge clk);
    lk_valid = 1'b1; lk_va = va; lk_asid = id; lk_store = st;
    @(posedge clk); #2;
    lk_valid = 1'b0; lk_store = 1'b0;
  endtask

  task automatic set_wr(input logic rnd, input logic [4:0] idx, input logic [20:0] vpn,
                        input logic [7:0] id, input logic gl, input logic [2:0] psz,
                        input logic [21:0] p0, input logic [21:0] p1,
                        input logic [3:0] vd);
    wr_rand = rnd; wr_idx = idx; wr_vpn = vpn; wr_asid = id; wr_glob = gl;
    wr_psz = psz; wr_pfn0 = p0; wr_pfn1 = p1;
    {wr_v0, wr_v1, wr_d0, wr_d1} = vd;
  endtask

  task automatic write(input logic rnd, input logic [4:0] idx, input logic [20:0] vpn,
                       input logic [7:0] id, input logic gl, input logic [2:0] psz,
                       input logic [21:0] p0, input logic [21:0] p1, input logic [3:0] vd);
    @(negedge clk);
    set_wr(rnd, idx, vpn, id, gl, psz, p0, p1, vd);
    wr_en = 1'b1;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    // R1: outputs clear after reset
    check("R1", {rsp_valid, tlb_shutdown, resp()}, '0);

    // slot loads by index (R9)
    write(0, 5'd0,  21'h00800, 8'd5, 0, 3'd1, 22'h00100, 22'h00200, 4'b1110);
    write(0, 5'd3,  21'h20000, 8'd0, 1, 3'd4, 22'h10000, 22'h20000, 4'b1011);
    write(0, 5'd7,  21'h40001, 8'd2, 0, 3'd0, 22'h00005, 22'h00007, 4'b1111);
    write(0, 5'd10, 21'h60000, 8'd1, 0, 3'd3, 22'h00800, 22'h00C00, 4'b1111);
    write(0, 5'd12, 21'h80000, 8'd1, 0, 3'd2, 22'h00040, 22'h00080, 4'b1111);

    for (int i = 0; i < NV; i++) begin
      lookup(VECS[i][79:48], VECS[i][47:40], VECS[i][36]);
      check($sformatf("R3/R4/R5/R6/R7/R8/R2 vec %0d", i), resp(), VECS[i][35:0]);
    end

    // R9: overwrite slot 0 with a new id
    write(0, 5'd0, 21'h00800, 8'd6, 0, 3'd1, 22'h00100, 22'h00200, 4'b1110);
    lookup(32'h00400ABC, 8'd6, 0);
    check("R9 new id hits", resp(), {4'b1000, 32'h00040ABC});
    lookup(32'h00400ABC, 8'd5, 0);
    check("R9 old id misses", resp(), {4'b0100, 32'h0});

    // R12: write and lookup in the same cycle
    @(negedge clk);
    set_wr(0, 5'd20, 21'hC0000, 8'd3, 0, 3'd1, 22'h00100, 22'h0, 4'b1010);
    wr_en = 1'b1; lk_valid = 1'b1; lk_va = 32'h60000020; lk_asid = 8'd3;
    @(posedge clk); #2;
    wr_en = 1'b0; lk_valid = 1'b0;
    check("R12 same cycle old", resp(), {4'b0100, 32'h0});
    lookup(32'h60000020, 8'd3, 0);
    check("R12 next cycle new", resp(), {4'b1000, 32'h00040020});

    // R10: random slot choice at wrap (31) and floor (8)
    write(0, 5'd31, 21'hA0000, 8'd3, 0, 3'd1, 22'h00300, 22'h0, 4'b1010);
    write(0, 5'd8,  21'hB0000, 8'd3, 0, 3'd1, 22'h00340, 22'h0, 4'b1010);
    lookup(32'h50000010, 8'd3, 0);
    check("R10 slot 31 preload", resp(), {4'b1000, 32'h000C0010});
    @(negedge clk);
    while (ecnt < 24 || (ecnt % 24) != 0) @(negedge clk);
    set_wr(1, 5'd0, 21'hE0000, 8'd3, 0, 3'd1, 22'h00380, 22'h0, 4'b1010);
    wr_en = 1'b1;
    @(posedge clk); #2; wr_en = 1'b0;
    @(negedge clk);
    while ((ecnt % 24) != 23) @(negedge clk);
    set_wr(1, 5'd0, 21'hF0000, 8'd3, 0, 3'd1, 22'h003C0, 22'h0, 4'b1010);
    wr_en = 1'b1;
    @(posedge clk); #2; wr_en = 1'b0;
    lookup(32'h50000010, 8'd3, 0);
    check("R10 slot 31 replaced", resp(), {4'b0100, 32'h0});
    lookup(32'h70000010, 8'd3, 0);
    check("R10 wrap write hits", resp(), {4'b1000, 32'h000E0010});
    lookup(32'h58000010, 8'd3, 0);
    check("R10 slot 8 replaced", resp(), {4'b0100, 32'h0});
    lookup(32'h78000010, 8'd3, 0);
    check("R10 floor write hits", resp(), {4'b1000, 32'h000F0010});
    lookup(32'h40003FFF, 8'd1, 0);
    check("R10 other slots intact", resp(), {4'b1000, 32'h00013FFF});

    // R11: duplicate match shuts down
    write(0, 5'd1, 21'h40001, 8'd2, 0, 3'd0, 22'h00009, 22'h0000B, 4'b1111);
    check("R11 flag clear before", {31'b0, tlb_shutdown}, '0);
    lookup(32'h20000A55, 8'd2, 0);
    check("R11 multi misses", {rsp_miss, rsp_hit, tlb_shutdown, 33'b0}, {3'b101, 33'b0});
    lookup(32'h00400ABC, 8'd6, 0);
    check("R11 single match forced miss", resp(), {4'b0100, 32'h0});
    lookup(32'h81234567, 8'd0, 0);
    check("R11/R2 bypass unaffected", resp(), {4'b1000, 32'h01234567});
    repeat (5) @(negedge clk);
    check("R11 flag held", {31'b0, tlb_shutdown}, 32'h1);

    // R1: reset clears shutdown and slots
    do_reset();
    #1;
    check("R1 shutdown cleared", {rsp_valid, tlb_shutdown, resp()}, '0);
    lookup(32'h20000A55, 8'd2, 0);
    check("R1 slots unused after reset", resp(), {4'b0100, 32'h0});

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule